// File: doc/BRIEF.md
# Dual Multi-Mode Timer/Counter

This block holds two 16-bit count units. Each unit is stored as a low byte and a high byte. One mode register configures both units, and one control register starts, stops and reports them. A unit advances on one of two sources. The first is an internal tick that fires once every twelve clocks. The second is a falling edge on that unit's external count pin. A gate pin can also make counting depend on an outside level. When a count wraps, the unit's overflow flag is set. The flag stays set until software clears it or the acknowledge input for that unit is pulsed.

A processor reaches every register through a flat byte-wide port. A write takes effect on the rising clock edge while `bus_we` is high. A read is combinational from `bus_addr`. Each unit runs in one of four modes:

- a 13-bit count;
- a 16-bit count;
- an 8-bit count that reloads from the high byte;
- a split mode, in which unit 0 becomes two independent 8-bit counters.

Top module: `dual_tmr_top`

## Requirements
- R1: After reset, every register reads 00h, both run bits are 0 and `ovf_flag` is 00.
- R2: With source select clear, a running unit advances exactly once in any window of 12 consecutive clocks. A unit whose run bit is 0 holds its count.
- R3: Mode 01 counts {high, low} as 16 bits. The step from FFFFh to 0000h sets the unit's flag.
- R4: Mode 00 counts {high, low[4:0]} as 13 bits. Low bits 7:5 keep their written value. The step from 1FFFh to 0000h sets the flag.
- R5: Mode 10 counts only the low byte. When the low byte is at FFh, the next step loads the high byte into the low byte and sets the flag.
- R6: Mode 11 on unit 0 works as follows. Its low byte is an 8-bit counter under unit 0's run, gate and source, and wrapping it sets flag 0. Its high byte counts internal ticks whenever run bit 1 is set, and wrapping it sets flag 1. Unit 1's own overflow does not set flag 1 while unit 0 is in split mode.
- R7: Unit 1 placed in mode 11 holds its count.
- R8: With source select set, a running unit advances once for each high-to-low transition of its count pin. The pin must hold each level for at least 14 clocks. The internal tick alone does not advance the count.
- R9: With gate enable set, the unit counts only while its gate pin is high.
- R10: Writing the control register with a 0 in a flag bit clears that flag. Writing a 1 in a flag bit leaves it unchanged. An `ovf_ack` pulse also clears the flag.
- R11: A bus write to a count byte takes priority over an increment of that unit in the same cycle.
- R12: The register map is as follows. Address 0 is mode. Address 1 is control, with bit 0 = run 0, bit 1 = run 1, bit 2 = flag 0 and bit 3 = flag 1. Addresses 2 and 3 are unit 0 low and high. Addresses 4 and 5 are unit 1 low and high. In the mode register, bits 3:0 belong to unit 0 and bits 7:4 to unit 1. Each nibble holds {gate enable, source select, mode[1:0]}. Addresses 6 and 7 ignore writes and read 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| cnt_pin | input | 2 | External count inputs, bit n for unit n |
| gate_pin | input | 2 | External gate levels, bit n for unit n |
| ovf_ack | input | 2 | Overflow flag clear pulses, bit n for flag n |
| ovf_flag | output | 2 | Overflow flags, bit n for flag n |

## Verification
The hardest case to reach from the ports is a bus write that lands on the same edge as a prescaler tick. The bench cannot see the prescaler phase. It therefore writes a count byte on every edge across two full prescale periods and reads the byte back after each edge, so one of those writes is certain to meet a tick. Timer-mode counts are predicted exactly in the same way, without knowing the phase. Each run window is opened and closed by control writes exactly 12·K edges apart, and any such window holds exactly K ticks.

// File: rtl/dtc_pkg.sv
// Shared types and register map for the dual timer/counter.
// Assumes a byte-wide register port with at most eight addresses.
package dtc_pkg;
    localparam int NUNIT  = 2;
    localparam int ADDR_W = 3;
    localparam int DATA_W = 8;

    localparam logic [ADDR_W-1:0] ADDR_MODE = 3'd0;
    localparam logic [ADDR_W-1:0] ADDR_CTRL = 3'd1;
    localparam logic [ADDR_W-1:0] ADDR_LO0  = 3'd2;

    localparam int CTRL_RUN_LSB  = 0;
    localparam int CTRL_FLAG_LSB = 2;

    typedef enum logic [1:0] {
        MODE_13     = 2'b00,
        MODE_16     = 2'b01,
        MODE_RELOAD = 2'b10,
        MODE_SPLIT  = 2'b11
    } cnt_mode_e;

    typedef struct packed {
        logic       gate_en;
        logic       ext_src;
        logic [1:0] mode;
    } unit_cfg_t;
endpackage

// File: rtl/dtc_prescale.sv
// Free-running divider producing a one-cycle tick every DIV clocks.
// Assumes DIV >= 1; the phase starts at reset and is never realigned.
module dtc_prescale #(
    parameter int DIV = 12
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    // Count 0..DIV-1 and wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                   cnt_q <= cnt_q + 1'b1;
    end

    assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/dtc_pin_sync.sv
// Multi-stage synchronizer for a vector of asynchronous input pins.
// Assumes STAGES >= 2; the output is the level seen after STAGES clocks.
module dtc_pin_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] level_o
);
    logic [W-1:0] stg_q [STAGES];

    // Shift each pin through the stage chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
        end else begin
            stg_q[0] <= pin_i;
            for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
        end
    end

    assign level_o = stg_q[STAGES-1];
endmodule

// File: rtl/dtc_count_unit.sv
// One count unit: low and high byte with four counting modes.
// Assumes the step inputs are already qualified by run, gate and source.
// A bus write to either byte cancels the unit's main step in that cycle.
// In split mode, a write cancels only the step of the byte written.
// SPLIT_OK selects whether mode 11 splits the unit (1) or holds it (0).
module dtc_count_unit
    import dtc_pkg::*;
#(
    parameter bit SPLIT_OK = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_i,
    input  logic              step_main_i,
    input  logic              step_aux_i,
    input  logic              wr_lo_i,
    input  logic              wr_hi_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] lo_o,
    output logic [DATA_W-1:0] hi_o,
    output logic              ovf_main_o,
    output logic              ovf_aux_o
);
    localparam int W13 = DATA_W + 5;
    localparam int W16 = 2 * DATA_W;

    logic [DATA_W-1:0] lo_q, hi_q, lo_d, hi_d;
    logic [W13-1:0]    cur13, inc13;
    logic [W16-1:0]    cur16, inc16;
    logic              wr_any;

    assign cur13  = {hi_q, lo_q[4:0]};
    assign inc13  = cur13 + 1'b1;
    assign cur16  = {hi_q, lo_q};
    assign inc16  = cur16 + 1'b1;
    assign wr_any = wr_lo_i | wr_hi_i;

    // Next-state and overflow pulses for the selected mode.
    always_comb begin
        lo_d       = lo_q;
        hi_d       = hi_q;
        ovf_main_o = 1'b0;
        ovf_aux_o  = 1'b0;
        case (cnt_mode_e'(mode_i))
            MODE_13: begin
                if (step_main_i && !wr_any) begin
                    hi_d       = inc13[W13-1:5];
                    lo_d       = {lo_q[7:5], inc13[4:0]};
                    ovf_main_o = &cur13;
                end
            end
            MODE_16: begin
                if (step_main_i && !wr_any) begin
                    {hi_d, lo_d} = inc16;
                    ovf_main_o   = &cur16;
                end
            end
            MODE_RELOAD: begin
                if (step_main_i && !wr_any) begin
                    if (&lo_q) begin
                        lo_d       = hi_q;
                        ovf_main_o = 1'b1;
                    end else begin
                        lo_d = lo_q + 1'b1;
                    end
                end
            end
            default: begin
                if (SPLIT_OK) begin
                    if (step_main_i && !wr_lo_i) begin
                        lo_d       = lo_q + 1'b1;
                        ovf_main_o = &lo_q;
                    end
                    if (step_aux_i && !wr_hi_i) begin
                        hi_d      = hi_q + 1'b1;
                        ovf_aux_o = &hi_q;
                    end
                end
            end
        endcase
        if (wr_lo_i) lo_d = wdata_i;
        if (wr_hi_i) hi_d = wdata_i;
    end

    // Count byte registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            lo_q <= lo_d;
            hi_q <= hi_d;
        end
    end

    assign lo_o = lo_q;
    assign hi_o = hi_q;
endmodule

// File: rtl/dual_tmr_top.sv
// Dual timer/counter top: register port, run/flag control, step qualification.
// Assumes cnt_pin and gate_pin are asynchronous; both pass through synchronizers.
// Count-pin falls are judged once per prescaler tick, so at most one step per tick.
module dual_tmr_top
    import dtc_pkg::*;
#(
    parameter int PRESCALE    = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NUNIT-1:0]  cnt_pin,
    input  logic [NUNIT-1:0]  gate_pin,
    input  logic [NUNIT-1:0]  ovf_ack,
    output logic [NUNIT-1:0]  ovf_flag
);
    localparam int NPIN = 2 * NUNIT;

    logic                          tick;
    logic [DATA_W-1:0]             mode_q;
    logic [NUNIT-1:0]              run_q, flag_q;
    logic [NUNIT-1:0][DATA_W-1:0]  lo_q, hi_q;
    logic [NUNIT-1:0]              cnt_lvl, gate_lvl, cnt_prev_q;
    logic [NUNIT-1:0]              step_main, step_aux, ovf_main, ovf_aux;
    logic [NUNIT-1:0]              wr_lo, wr_hi, set_evt, clr_evt;
    logic                          wr_mode, wr_ctrl, split0;
    unit_cfg_t                     cfg [NUNIT];

    dtc_prescale #(.DIV(PRESCALE)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    dtc_pin_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_i   ({gate_pin, cnt_pin}),
        .level_o ({gate_lvl, cnt_lvl})
    );

    // Previous count-pin sample, refreshed once per tick.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_prev_q <= '0;
        else if (tick) cnt_prev_q <= cnt_lvl;
    end

    assign wr_mode = bus_we && (bus_addr == ADDR_MODE);
    assign wr_ctrl = bus_we && (bus_addr == ADDR_CTRL);
    assign split0  = (cfg[0].mode == MODE_SPLIT);

    for (genvar u = 0; u < NUNIT; u++) begin : g_unit
        assign cfg[u]   = unit_cfg_t'(mode_q[4*u +: 4]);
        assign wr_lo[u] = bus_we && (bus_addr == ADDR_LO0 + ADDR_W'(2*u));
        assign wr_hi[u] = bus_we && (bus_addr == ADDR_LO0 + ADDR_W'(2*u + 1));
        assign step_main[u] = tick && run_q[u]
                            && (!cfg[u].gate_en || gate_lvl[u])
                            && (!cfg[u].ext_src || (cnt_prev_q[u] && !cnt_lvl[u]));
        if (u == 0) begin : g_aux
            assign step_aux[u] = tick && run_q[NUNIT-1];
        end else begin : g_noaux
            assign step_aux[u] = 1'b0;
        end
        assign clr_evt[u] = ovf_ack[u]
                          || (wr_ctrl && !bus_wdata[CTRL_FLAG_LSB + u]);

        dtc_count_unit #(.SPLIT_OK(u == 0)) u_cnt (
            .clk         (clk),
            .rst_n       (rst_n),
            .mode_i      (cfg[u].mode),
            .step_main_i (step_main[u]),
            .step_aux_i  (step_aux[u]),
            .wr_lo_i     (wr_lo[u]),
            .wr_hi_i     (wr_hi[u]),
            .wdata_i     (bus_wdata),
            .lo_o        (lo_q[u]),
            .hi_o        (hi_q[u]),
            .ovf_main_o  (ovf_main[u]),
            .ovf_aux_o   (ovf_aux[u])
        );
    end

    // Flag sources: unit 0's split high byte replaces unit 1 as source of flag 1.
    assign set_evt[0] = ovf_main[0];
    assign set_evt[1] = split0 ? ovf_aux[0] : (ovf_main[1] | ovf_aux[1]);

    // Mode, run and flag registers; a set outranks a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            run_q  <= '0;
            flag_q <= '0;
        end else begin
            if (wr_mode) mode_q <= bus_wdata;
            if (wr_ctrl) run_q <= bus_wdata[CTRL_RUN_LSB +: NUNIT];
            flag_q <= (flag_q & ~clr_evt) | set_evt;
        end
    end

    // Combinational read mux.
    always_comb begin
        case (bus_addr)
            3'd0:    bus_rdata = mode_q;
            3'd1:    bus_rdata = {4'b0, flag_q, run_q};
            3'd2:    bus_rdata = lo_q[0];
            3'd3:    bus_rdata = hi_q[0];
            3'd4:    bus_rdata = lo_q[1];
            3'd5:    bus_rdata = hi_q[1];
            default: bus_rdata = '0;
        endcase
    end

    assign ovf_flag = flag_q;
endmodule

// File: rtl/dtc_checker.sv
// Property checker for dual_tmr_top, attached by bind below.
// Assumes it sees the top's internal tick, run, mode, count and flag-set state.
module dtc_checker (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_we,
    input logic             tick,
    input logic [1:0]       run_q,
    input logic [7:0]       mode_reg,
    input logic             set0,
    input logic [1:0]       ovf_ack,
    input logic [1:0]       ovf_flag,
    input logic [1:0][7:0]  lo_q,
    input logic [1:0][7:0]  hi_q
);
    // R1: flags come out of reset cleared.
    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (ovf_flag == 2'b00));

    // R2: no count moves on a cycle without a tick and without a write.
    assert_no_tick_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !bus_we) |=> ($stable(lo_q) && $stable(hi_q)));

    // R2: both run bits off and no write means nothing counts.
    assert_stopped_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q == 2'b00 && !bus_we) |=> ($stable(lo_q) && $stable(hi_q)));

    // R3: an overflow event leaves flag 0 set.
    assert_flag_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        set0 |=> ovf_flag[0]);

    // R5: a reload-mode overflow copies the high byte into the low byte.
    assert_reload_copy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_reg[1:0] == 2'b10 && set0 && !bus_we) |=> (lo_q[0] == $past(hi_q[0])));

    // R7: unit 1 in mode 11 holds.
    assert_unit1_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_reg[5:4] == 2'b11 && !bus_we) |=> ($stable(lo_q[1]) && $stable(hi_q[1])));

    // R10: acknowledge clears flag 0 when no overflow coincides.
    assert_ack_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_ack[0] && !set0) |=> !ovf_flag[0]);
endmodule

bind dual_tmr_top dtc_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_we   (bus_we),
    .tick     (tick),
    .run_q    (run_q),
    .mode_reg (mode_q),
    .set0     (set_evt[0]),
    .ovf_ack  (ovf_ack),
    .ovf_flag (ovf_flag),
    .lo_q     (lo_q),
    .hi_q     (hi_q)
);

// File: tb/sim_dual_tmr_top.sv
`timescale 1ns/1ps
// Self-checking bench: table-driven register sequences, then directed cases.
module sim_dual_tmr_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_we = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [1:0] cnt_pin = '0, gate_pin = '0, ovf_ack = '0, ovf_flag;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    dual_tmr_top u0 (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cnt_pin(cnt_pin),
        .gate_pin(gate_pin), .ovf_ack(ovf_ack), .ovf_flag(ovf_flag)
    );

    typedef struct packed {
        logic [2:0]  wa;
        logic [7:0]  wd;
        logic [15:0] wt;
        logic        chk;
        logic [2:0]  ra;
        logic [7:0]  ex;
        logic [7:0]  req;
    } vec_t;

    // Each row: write wa<=wd, wait wt more edges, optionally read ra expecting ex.
    // Run windows span wt+1 edges, so wt = 12K-1 gives exactly K ticks.
    localparam int NV = 49;
    localparam vec_t VEC [NV] = '{
        // R3 16-bit wrap (R2 rate: 36 edges -> 3 ticks)
        '{3'd0, 8'h01, 16'd0,  1'b0, 3'd0, 8'h00, 8'd3},
        '{3'd2, 8'hFE, 16'd0,  1'b0, 3'd0, 8'h00, 8'd3},
        '{3'd3, 8'hFF, 16'd0,  1'b0, 3'd0, 8'h00, 8'd3},
        '{3'd1, 8'h01, 16'd35, 1'b0, 3'd0, 8'h00, 8'd2},
        '{3'd1, 8'h0C, 16'd0,  1'b1, 3'd2, 8'h01, 8'd3},
        '{3'd7, 8'h00, 16'd0,  1'b1, 3'd3, 8'h00, 8'd3},
        '{3'd7, 8'h00, 16'd0,  1'b1, 3'd1, 8'h04, 8'd3},
        '{3'd1, 8'h08, 16'd0,  1'b1, 3'd1, 8'h00, 8'd10},
        // R4 13-bit wrap, low[7:5] kept
        '{3'd0, 8'h00, 16'd0,  1'b0, 3'd0, 8'h00, 8'd4},
        '{3'd2, 8'hFE, 16'd0,  1'b0, 3'd0, 8'h00, 8'd4},
        '{3'd3, 8'hFF, 16'd0,  1'b0, 3'd0, 8'h00, 8'd4},
        '{3'd1, 8'h01, 16'd35, 1'b0, 3'd0, 8'h00, 8'd4},
        '{3'd1, 8'h0C, 16'd0,  1'b1, 3'd2, 8'hE1, 8'd4},
        '{3'd7, 8'h00, 16'd0,  1'b1, 3'd3, 8'h00, 8'd4},
        '{3'd7, 8'h00, 16'd0,  1'b1, 3'd1, 8'h04, 8'd4},
        '{3'd1, 8'h08, 16'd0,  1'b1, 3'd1, 8'h00, 8'd10},
        // R5 reload on unit 1
        '{3'd0, 8'h20, 16'd0,  1'b0, 3'd0, 8'h00, 8'd5},
        '{3'd5, 8'h80, 16'd0,  1'b0, 3'd0, 8'h00, 8'd5},
        '{3'd4, 8'hFE, 16'd0,  1'b0, 3'd0, 8'h00, 8'd5},
        '{3'd1, 8'h02, 16'd47, 1'b0, 3'd0, 8'h00, 8'd5},
        '{3'd1, 8'h0C, 16'd0,  1'b1, 3'd4, 8'h82, 8'd5},
        '{3'd7, 8'h00, 16'd0,  1'b1, 3'd5, 8'h80, 8'd5},
        '{3'd7, 8'h00, 16'd0,  1'b1, 3'd1, 8'h08, 8'd5},
        '{3'd1, 8'h04, 16'd0,  1'b1, 3'd1, 8'h00, 8'd10},
        // R6 split mode on unit 0
        '{3'd0, 8'h03, 16'd0,  1'b0, 3'd0, 8'h00, 8'd6},
        '{3'd2, 8'hFF, 16'd0,  1'b0, 3'd0, 8'h00, 8'd6},
        '{3'd3, 8'hFE, 16'd0,  1'b0, 3'd0, 8'h00, 8'd6},
        '{3'd4, 8'h00, 16'd0,  1'b0, 3'd0, 8'h00, 8'd6},
        '{3'd5, 8'h00, 16'd0,  1'b0, 3'd0, 8'h00, 8'd6},
        '{3'd1, 8'h03, 16'd23, 1'b0, 3'd0, 8'h00, 8'd6},
        '{3'd1, 8'h0C, 16'd0,  1'b1, 3'd2, 8'h01, 8'd6},
        '{3'd7, 8'h00, 16'd0,  1'b1, 3'd3, 8'h00, 8'd6},
        '{3'd7, 8'h00, 16'd0,  1'b1, 3'd4, 8'h02, 8'd6},
        '{3'd7, 8'h00, 16'd0,  1'b1, 3'd1, 8'h0C, 8'd6},
        // R7 unit 1 in mode 11 holds
        '{3'd1, 8'h00, 16'd0,  1'b1, 3'd1, 8'h00, 8'd10},
        '{3'd0, 8'h30, 16'd0,  1'b0, 3'd0, 8'h00, 8'd7},
        '{3'd1, 8'h02, 16'd35, 1'b0, 3'd0, 8'h00, 8'd7},
        '{3'd1, 8'h00, 16'd0,  1'b1, 3'd4, 8'h02, 8'd7},
        // R6 unit 1 wrap does not reach flag 1 during split
        '{3'd0, 8'h13, 16'd0,  1'b0, 3'd0, 8'h00, 8'd6},
        '{3'd4, 8'hFF, 16'd0,  1'b0, 3'd0, 8'h00, 8'd6},
        '{3'd5, 8'hFF, 16'd0,  1'b0, 3'd0, 8'h00, 8'd6},
        '{3'd3, 8'h00, 16'd0,  1'b0, 3'd0, 8'h00, 8'd6},
        '{3'd1, 8'h02, 16'd11, 1'b0, 3'd0, 8'h00, 8'd6},
        '{3'd1, 8'h0C, 16'd0,  1'b1, 3'd1, 8'h00, 8'd6},
        '{3'd7, 8'h00, 16'd0,  1'b1, 3'd4, 8'h00, 8'd6},
        '{3'd7, 8'h00, 16'd0,  1'b1, 3'd3, 8'h01, 8'd6},
        // R12 unused addresses and mode readback
        '{3'd6, 8'h55, 16'd0,  1'b1, 3'd6, 8'h00, 8'd12},
        '{3'd7, 8'h00, 16'd0,  1'b1, 3'd0, 8'h13, 8'd12},
        // R2 stopped units hold
        '{3'd1, 8'h00, 16'd47, 1'b1, 3'd4, 8'h00, 8'd2}
    };

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input int req);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL R%0d: got %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic do_vec(input logic [2:0] wa, input logic [7:0] wd, input int wt,
                          input bit chk, input logic [2:0] ra, input logic [7:0] ex,
                          input int req);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = wa; bus_wdata = wd;
        @(negedge clk);
        bus_we = 1'b0; bus_addr = ra;
        repeat (wt) @(negedge clk);
        if (chk) begin
            #1;
            check(bus_rdata, ex, req);
        end
    endtask

    task automatic rd(input logic [2:0] ra, input logic [7:0] ex, input int req);
        @(negedge clk);
        bus_addr = ra;
        #1;
        check(bus_rdata, ex, req);
    endtask

    bit done = 1'b0;

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        for (int a = 0; a < 6; a++) rd(3'(a), 8'h00, 1);
        check({6'b0, ovf_flag}, 8'h00, 1);

        for (int i = 0; i < NV; i++)
            do_vec(VEC[i].wa, VEC[i].wd, int'(VEC[i].wt), VEC[i].chk,
                   VEC[i].ra, VEC[i].ex, int'(VEC[i].req));

        // R8 counter source: three pin falls, no internal counting
        do_vec(3'd0, 8'h05, 0, 1'b0, 3'd0, 8'h00, 8);
        do_vec(3'd2, 8'h00, 0, 1'b0, 3'd0, 8'h00, 8);
        do_vec(3'd3, 8'h00, 0, 1'b0, 3'd0, 8'h00, 8);
        do_vec(3'd1, 8'h01, 0, 1'b0, 3'd0, 8'h00, 8);
        for (int k = 0; k < 3; k++) begin
            cnt_pin[0] = 1'b1;
            repeat (30) @(negedge clk);
            cnt_pin[0] = 1'b0;
            repeat (30) @(negedge clk);
        end
        do_vec(3'd1, 8'h00, 0, 1'b1, 3'd2, 8'h03, 8);
        rd(3'd3, 8'h00, 8);

        // R9 gate: low gate pin blocks, high gate pin allows
        do_vec(3'd0, 8'h09, 0, 1'b0, 3'd0, 8'h00, 9);
        do_vec(3'd2, 8'h00, 0, 1'b0, 3'd0, 8'h00, 9);
        do_vec(3'd1, 8'h01, 47, 1'b0, 3'd0, 8'h00, 9);
        do_vec(3'd1, 8'h00, 0, 1'b1, 3'd2, 8'h00, 9);
        gate_pin[0] = 1'b1;
        do_vec(3'd7, 8'h00, 5, 1'b0, 3'd0, 8'h00, 9);
        do_vec(3'd1, 8'h01, 47, 1'b0, 3'd0, 8'h00, 9);
        do_vec(3'd1, 8'h00, 0, 1'b1, 3'd2, 8'h04, 9);

        // R10 acknowledge input clears the flag
        do_vec(3'd0, 8'h02, 0, 1'b0, 3'd0, 8'h00, 10);
        do_vec(3'd3, 8'hFF, 0, 1'b0, 3'd0, 8'h00, 10);
        do_vec(3'd2, 8'hFF, 0, 1'b0, 3'd0, 8'h00, 10);
        do_vec(3'd1, 8'h01, 11, 1'b0, 3'd0, 8'h00, 10);
        do_vec(3'd1, 8'h04, 0, 1'b1, 3'd1, 8'h04, 10);
        check({6'b0, ovf_flag}, 8'h01, 10);
        rd(3'd2, 8'hFF, 5);
        @(negedge clk); ovf_ack[0] = 1'b1;
        @(negedge clk); ovf_ack[0] = 1'b0;
        rd(3'd1, 8'h00, 10);

        // R11 writes on every edge of two prescale periods while running
        do_vec(3'd0, 8'h01, 0, 1'b0, 3'd0, 8'h00, 11);
        do_vec(3'd3, 8'h10, 0, 1'b0, 3'd0, 8'h00, 11);
        do_vec(3'd1, 8'h01, 0, 1'b0, 3'd0, 8'h00, 11);
        begin
            int bad_wr;
            bad_wr = 0;
            for (int k = 0; k < 24; k++) begin
                @(negedge clk);
                bus_we = 1'b1; bus_addr = 3'd2; bus_wdata = 8'h40;
                @(negedge clk);
                #1;
                if (bus_rdata !== 8'h40) bad_wr++;
            end
            bus_we = 1'b0;
            check(8'(bad_wr), 8'h00, 11);
        end
        do_vec(3'd1, 8'h00, 0, 1'b0, 3'd0, 8'h00, 11);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule